// File: doc/BRIEF.md
# PROM/RAM External Memory Controller with Wait States

This block sits between an internal 32-bit request port and an asynchronous external memory bus that carries boot PROM and static RAM. It decodes each request address into a PROM region or a RAM region and drives the matching active-low chip select. It holds each memory cycle for a programmable number of wait states and returns read data or an error on a one-cycle response pulse. The PROM region has two selects, one for each half. The RAM region is split into four contiguous banks, and one configuration field sets the size of every bank.

The RAM is only ever accessed as whole 32-bit words. A write that does not enable all four bytes becomes a read of the word, a merge of the enabled bytes, and a full-word write-back. A PROM write goes out directly with per-byte strobes. A protect bit in the configuration word blocks every RAM write and answers it with an error. Reads may ask for a burst over consecutive words; the chip select stays low from the first beat to the last.

A single configuration word, written through a strobe, sets the wait states, the protect bit and the bank size. Requests are taken only while the controller is idle, which `req_ready` shows.

Top module: `extmem_ctrl`

## Requirements
- R1: Word addresses below 0x20000000 (bytes) select the PROM. Address bit 28 clear asserts `prom_cs_n[0]`, and bit 28 set asserts `prom_cs_n[1]`.
- R2: At most one of the six chip selects (`prom_cs_n[1:0]`, `ram_cs_n[3:0]`) is low in any cycle.
- R3: The RAM region starts at byte 0x40000000. Bank k covers offsets from k*S to (k+1)*S-1, where S = 8 KiB << `cfg_wdata[10:7]`, and asserts `ram_cs_n[k]`.
- R4: A PROM access holds its chip select low for P+1 cycles, where P = `cfg_wdata[3:0]` (0 to 15). The response pulse follows in the cycle after the select is released.
- R5: A RAM access phase holds its chip select low for W+1 cycles, where W = `cfg_wdata[5:4]` (0 to 3).
- R6: A RAM write with `req_be` other than 4'hF runs as a read phase with `mem_oe_n` low, followed by a write phase with `mem_we_n` low and every `mem_wbe_n` bit low. The stored word takes the enabled bytes from `req_wdata` and keeps the other bytes. A RAM write with `req_be` of 4'hF has no read phase.
- R7: A PROM write has no read phase and drives `mem_wbe_n` equal to the inverse of `req_be`.
- R8: While `cfg_wdata[6]` is set, every RAM write responds with `rsp_err` high and leaves memory unchanged, with no select and no write strobe. RAM reads and PROM writes are unaffected.
- R9: An address outside the PROM region and outside every RAM bank responds with `rsp_err` high in the cycle after acceptance, with no select or strobe.
- R10: A read with `req_len` = L produces L+1 responses from consecutive word addresses. Each beat waits the full wait-state count, and the chip select stays low across all beats. Writes ignore `req_len`.
- R11: After reset, all selects and strobes are high, no response is pending, and `req_ready` is high. The wait-state fields reset to 15 (PROM) and 3 (RAM), protection resets off, and the bank size field resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 11 | Configuration word: [3:0] PROM waits, [5:4] RAM waits, [6] RAM protect, [10:7] bank size |
| req_valid | input | 1 | Request present; taken when `req_ready` is high |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 30 | Word address (byte address bits 31:2) |
| req_be | input | 4 | Byte enables for writes |
| req_wdata | input | 32 | Write data |
| req_len | input | 3 | Extra read beats after the first |
| rsp_valid | output | 1 | One-cycle response pulse per beat |
| rsp_err | output | 1 | Error flag with the response |
| rsp_rdata | output | 32 | Read data with the response |
| mem_addr | output | 30 | External word address |
| mem_wdata | output | 32 | External write data |
| mem_rdata | input | 32 | External read data |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_wbe_n | output | 4 | Byte write strobes, active low |
| prom_cs_n | output | 2 | PROM half selects, active low |
| ram_cs_n | output | 4 | RAM bank selects, active low |

## Verification
The hardest case to reach is the read-modify-write sequence. Its merge outcome depends on the old memory contents, the byte-enable pattern and the RAM wait setting all at once. A faulty merge or a missing read phase shows only in the stored word or in the cycle counts. The bench sweeps all sixteen byte-enable patterns at two wait settings against a memory model it owns. For each write it checks the stored word, the read and write phase lengths and the strobes, then reads the word back through the controller. Out-of-bank errors depend on the bank-size field, so the bench reprograms that field and probes both sides of the last bank's edge.

// File: rtl/extmem_pkg.sv
package extmem_pkg;

    localparam int unsigned PROM_WS_W = 4;
    localparam int unsigned RAM_WS_W  = 2;
    localparam int unsigned SIZE_W    = 4;
    localparam int unsigned WADDR_W   = 30;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned BE_W      = DATA_W / 8;

    typedef enum logic [1:0] {
        RG_NONE,
        RG_PROM,
        RG_RAM
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_MRD,
        ST_MWR
    } state_e;

    typedef struct packed {
        logic [SIZE_W-1:0]    bank_size;
        logic                 wprot;
        logic [RAM_WS_W-1:0]  ram_ws;
        logic [PROM_WS_W-1:0] prom_ws;
    } cfg_t;

    localparam int unsigned CFG_W = $bits(cfg_t);

endpackage

// File: rtl/extmem_cfg.sv
module extmem_cfg
    import extmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.prom_ws   <= '1;
            cfg_q.ram_ws    <= '1;
            cfg_q.wprot     <= 1'b0;
            cfg_q.bank_size <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

    // R11: a write strobe is the only way the configuration changes
    p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr) |-> $stable(cfg_q))
        else $error("configuration changed without a write strobe");

endmodule

// File: rtl/extmem_decode.sv
module extmem_decode
    import extmem_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic [WADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0]  bank_size,
    output region_e            region,
    output logic               prom_upper,
    output logic [NUM_BANKS-1:0] bank_sel
);

    // 8 KiB is 2**11 words
    localparam int unsigned BASE_SHIFT = 11;
    localparam int unsigned OFF_W      = WADDR_W - 2;

    logic [OFF_W-1:0] ram_off;
    logic [OFF_W-1:0] bank_idx;

    always_comb begin
        ram_off    = addr[OFF_W-1:0];
        bank_idx   = ram_off >> (BASE_SHIFT + 32'(bank_size));
        prom_upper = addr[WADDR_W-4];
        region     = RG_NONE;
        bank_sel   = '0;
        if (addr[WADDR_W-1 -: 3] == 3'b000) begin
            region = RG_PROM;
        end else if (addr[WADDR_W-1 -: 2] == 2'b01) begin
            for (int b = 0; b < int'(NUM_BANKS); b++) begin
                if (bank_idx == OFF_W'(b)) begin
                    bank_sel[b] = 1'b1;
                end
            end
            if (|bank_sel) begin
                region = RG_RAM;
            end
        end
    end

endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
    import extmem_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned LEN_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr,
    input  logic [CFG_W-1:0]     cfg_wdata,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [WADDR_W-1:0]   req_addr,
    input  logic [BE_W-1:0]      req_be,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [LEN_W-1:0]     req_len,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic [WADDR_W-1:0]   mem_addr,
    output logic [DATA_W-1:0]    mem_wdata,
    input  logic [DATA_W-1:0]    mem_rdata,
    output logic                 mem_oe_n,
    output logic                 mem_we_n,
    output logic [BE_W-1:0]      mem_wbe_n,
    output logic [1:0]           prom_cs_n,
    output logic [NUM_BANKS-1:0] ram_cs_n
);

    typedef struct packed {
        state_e               st;
        logic [PROM_WS_W-1:0] cnt;
        logic [WADDR_W-1:0]   addr;
        logic [DATA_W-1:0]    wdata;
        logic [BE_W-1:0]      be;
        logic                 write_op;
        logic [LEN_W-1:0]     beats;
        logic [1:0]           prom_cs;
        logic [NUM_BANKS-1:0] ram_cs;
        logic                 oe;
        logic                 we;
        logic [BE_W-1:0]      wbe;
        logic                 rsp_valid;
        logic                 rsp_err;
        logic [DATA_W-1:0]    rsp_rdata;
    } ctl_t;

    cfg_t                 cfg;
    region_e              dec_region;
    logic                 dec_upper;
    logic [NUM_BANKS-1:0] dec_bank;
    logic [PROM_WS_W-1:0] ram_ws_ext;
    logic [DATA_W-1:0]    merged;
    ctl_t                 ctl_d, ctl_q;

    extmem_cfg i_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (cfg_wr),
        .wdata (cfg_wdata),
        .cfg   (cfg)
    );

    extmem_decode #(.NUM_BANKS(NUM_BANKS)) i_decode (
        .addr       (req_addr),
        .bank_size  (cfg.bank_size),
        .region     (dec_region),
        .prom_upper (dec_upper),
        .bank_sel   (dec_bank)
    );

    assign ram_ws_ext = PROM_WS_W'(cfg.ram_ws);

    always_comb begin
        for (int b = 0; b < int'(BE_W); b++) begin
            merged[b*8 +: 8] = ctl_q.be[b] ? ctl_q.wdata[b*8 +: 8] : mem_rdata[b*8 +: 8];
        end
    end

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_err   = 1'b0;
        ctl_d.rsp_rdata = '0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr     = req_addr;
                    ctl_d.wdata    = req_wdata;
                    ctl_d.be       = req_be;
                    ctl_d.write_op = req_write;
                    ctl_d.beats    = req_write ? '0 : req_len;
                    unique case (dec_region)
                        RG_PROM: begin
                            ctl_d.st      = ST_XFER;
                            ctl_d.cnt     = cfg.prom_ws;
                            ctl_d.prom_cs = dec_upper ? 2'b10 : 2'b01;
                            ctl_d.oe      = !req_write;
                            ctl_d.we      = req_write;
                            ctl_d.wbe     = req_write ? req_be : '0;
                        end
                        RG_RAM: begin
                            if (req_write && cfg.wprot) begin
                                ctl_d.rsp_valid = 1'b1;
                                ctl_d.rsp_err   = 1'b1;
                            end else begin
                                ctl_d.cnt    = ram_ws_ext;
                                ctl_d.ram_cs = dec_bank;
                                if (req_write && req_be != '1) begin
                                    ctl_d.st = ST_MRD;
                                    ctl_d.oe = 1'b1;
                                end else begin
                                    ctl_d.st  = ST_XFER;
                                    ctl_d.oe  = !req_write;
                                    ctl_d.we  = req_write;
                                    ctl_d.wbe = req_write ? '1 : '0;
                                end
                            end
                        end
                        default: begin
                            ctl_d.rsp_valid = 1'b1;
                            ctl_d.rsp_err   = 1'b1;
                        end
                    endcase
                end
            end
            ST_XFER: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.rsp_rdata = ctl_q.write_op ? '0 : mem_rdata;
                    if (ctl_q.beats != '0) begin
                        ctl_d.beats = ctl_q.beats - 1'b1;
                        ctl_d.addr  = ctl_q.addr + 1'b1;
                        ctl_d.cnt   = (|ctl_q.ram_cs) ? ram_ws_ext : cfg.prom_ws;
                    end else begin
                        ctl_d.st      = ST_IDLE;
                        ctl_d.prom_cs = '0;
                        ctl_d.ram_cs  = '0;
                        ctl_d.oe      = 1'b0;
                        ctl_d.we      = 1'b0;
                        ctl_d.wbe     = '0;
                    end
                end
            end
            ST_MRD: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.wdata = merged;
                    ctl_d.st    = ST_MWR;
                    ctl_d.oe    = 1'b0;
                    ctl_d.we    = 1'b1;
                    ctl_d.wbe   = '1;
                    ctl_d.cnt   = ram_ws_ext;
                end
            end
            ST_MWR: begin
                if (ctl_q.cnt != '0) begin
                    ctl_d.cnt = ctl_q.cnt - 1'b1;
                end else begin
                    ctl_d.rsp_valid = 1'b1;
                    ctl_d.st        = ST_IDLE;
                    ctl_d.ram_cs    = '0;
                    ctl_d.we        = 1'b0;
                    ctl_d.wbe       = '0;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready = (ctl_q.st == ST_IDLE);
    assign rsp_valid = ctl_q.rsp_valid;
    assign rsp_err   = ctl_q.rsp_err;
    assign rsp_rdata = ctl_q.rsp_rdata;
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = ctl_q.wdata;
    assign mem_oe_n  = !ctl_q.oe;
    assign mem_we_n  = !ctl_q.we;
    assign mem_wbe_n = ~ctl_q.wbe;
    assign prom_cs_n = ~ctl_q.prom_cs;
    assign ram_cs_n  = ~ctl_q.ram_cs;

    // R2: never two devices selected together
    p_one_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({~prom_cs_n, ~ram_cs_n}))
        else $error("more than one chip select active");

    // R4, R5: while the wait counter runs, the bus holds still
    p_wait_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st != ST_IDLE && ctl_q.cnt != '0) |=>
            ($stable(prom_cs_n) && $stable(ram_cs_n) && $stable(mem_addr)))
        else $error("bus changed during a wait state");

    // R6: RAM is written only as a whole word
    p_ram_word_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !(&ram_cs_n)) |-> (mem_wbe_n == '0))
        else $error("partial strobe on a RAM write");

    // R6: a write strobe inside a held RAM select follows a read phase
    p_rmw_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_we_n) && !(&ram_cs_n) && $past(!(&ram_cs_n))) |-> $past(!mem_oe_n))
        else $error("write-back without a read phase");

    // R6: never read and write together
    p_oe_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_oe_n && !mem_we_n))
        else $error("output and write enable both active");

    // R8: a protected RAM write never strobes and answers with an error
    p_wprot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid && req_write && cfg.wprot && dec_region == RG_RAM) |=>
            (mem_we_n && rsp_valid && rsp_err))
        else $error("protected RAM write reached the bus");

    // R9: an error response leaves the bus idle
    p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (mem_we_n && mem_oe_n && (&prom_cs_n) && (&ram_cs_n)))
        else $error("bus active with an error response");

    // R10: each further burst beat moves one word up
    p_burst_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_XFER && ctl_q.cnt == '0 && ctl_q.beats != '0) |=>
            (mem_addr == $past(mem_addr) + 1'b1 && !(&prom_cs_n && &ram_cs_n)))
        else $error("burst beat address or select wrong");

endmodule

// File: tb/test_extmem_ctrl.sv
module test_extmem_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [10:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [29:0] req_addr = '0;
    logic [3:0]  req_be = '0;
    logic [31:0] req_wdata = '0;
    logic [2:0]  req_len = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_oe_n, mem_we_n;
    logic [3:0]  mem_wbe_n;
    logic [1:0]  prom_cs_n;
    logic [3:0]  ram_cs_n;

    always #2 clk = ~clk;

    extmem_ctrl #(.NUM_BANKS(4), .LEN_W(3)) i_extmem_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata), .req_len(req_len),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_wbe_n(mem_wbe_n),
        .prom_cs_n(prom_cs_n), .ram_cs_n(ram_cs_n)
    );

    // external memory model
    logic [31:0] store [logic [29:0]];

    function automatic logic [31:0] init_word(logic [29:0] w);
        return {w, 2'b00} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic [31:0] rd_model(logic [29:0] w);
        return store.exists(w) ? store[w] : init_word(w);
    endfunction

    always @(negedge clk) mem_rdata = mem_oe_n ? 32'h0 : rd_model(mem_addr);

    always @(posedge clk) begin
        if (!mem_we_n) begin : wr_blk
            logic [31:0] w;
            w = rd_model(mem_addr);
            for (int b = 0; b < 4; b++) begin
                if (!mem_wbe_n[b]) w[b*8 +: 8] = mem_wdata[b*8 +: 8];
            end
            store[mem_addr] = w;
        end
    end

    // bus monitor
    int         mon_cs = 0, mon_oe = 0, mon_we = 0, mon_fall = 0;
    logic       prev_any = 1'b0;
    logic [5:0] last_cs = '0;
    logic [3:0] last_wbe = '0;
    always @(posedge clk) begin
        if (~&{prom_cs_n, ram_cs_n}) begin
            mon_cs  <= mon_cs + 1;
            last_cs <= {~prom_cs_n, ~ram_cs_n};
            if (!prev_any) mon_fall <= mon_fall + 1;
        end
        prev_any <= ~&{prom_cs_n, ram_cs_n};
        if (!mem_oe_n) mon_oe <= mon_oe + 1;
        if (!mem_we_n) begin
            mon_we   <= mon_we + 1;
            last_wbe <= ~mem_wbe_n;
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [10:0] cfg_word(int pw, int rw, int wp, int sz);
        return {4'(sz), 1'(wp), 2'(rw), 4'(pw)};
    endfunction

    task automatic set_cfg(int pw, int rw, int wp, int sz);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_wdata = cfg_word(pw, rw, wp, sz);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    logic [31:0] got_rd [8];
    logic        got_err;
    int          n_got, d_cs, d_oe, d_we, d_fall;

    task automatic xact(input logic wr, input logic [31:0] baddr, input logic [3:0] be,
                        input logic [31:0] wd, input int len);
        int c0, o0, w0, f0, n_exp;
        c0 = mon_cs; o0 = mon_oe; w0 = mon_we; f0 = mon_fall;
        n_exp = wr ? 1 : len + 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = baddr[31:2];
        req_be = be; req_wdata = wd; req_len = 3'(len);
        @(negedge clk);
        req_valid = 1'b0;
        n_got = 0; got_err = 1'b0;
        for (int t = 0; t < 400; t++) begin
            if (rsp_valid) begin
                got_rd[n_got] = rsp_rdata;
                if (rsp_err) got_err = 1'b1;
                n_got++;
            end
            if (n_got >= n_exp || got_err) break;
            @(negedge clk);
        end
        @(negedge clk);
        d_cs = mon_cs - c0; d_oe = mon_oe - o0; d_we = mon_we - w0; d_fall = mon_fall - f0;
    endtask

    initial begin
        #600000;
        $display("FAIL watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R11", "ready in reset", 32'(req_ready), 32'd1);
        chk("R11", "selects in reset", 32'({prom_cs_n, ram_cs_n}), 32'h3F);
        chk("R11", "strobes in reset", 32'({mem_oe_n, mem_we_n, mem_wbe_n}), 32'h3F);
        chk("R11", "no response in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;

        // R11, R4: default PROM wait is 15
        xact(1'b0, 32'h0000_0100, 4'h0, 32'h0, 0);
        chk("R11", "default PROM select cycles", 32'(d_cs), 32'd16);
        chk("R11", "default PROM read data", got_rd[0], init_word(30'h40));

        // R1, R2, R4: PROM sweep over waits and halves
        for (int ws = 0; ws < 16; ws++) begin
            set_cfg(ws, 0, 0, 0);
            for (int h = 0; h < 2; h++) begin
                logic [31:0] a;
                a = (h != 0 ? 32'h1000_0000 : 32'h0) + 32'(ws * 16);
                xact(1'b0, a, 4'h0, 32'h0, 0);
                chk("R1", "PROM read data", got_rd[0], init_word(a[31:2]));
                chk("R1", "PROM half select", 32'(last_cs), h != 0 ? 32'h20 : 32'h10);
                chk("R2", "single select", 32'($countones(last_cs)), 32'd1);
                chk("R4", "PROM select cycles", 32'(d_cs), 32'(ws + 1));
                chk("R4", "PROM no error", 32'(got_err), 32'd0);
            end
        end

        // R3, R5: RAM banks over sizes and waits
        for (int si = 0; si < 4; si++) begin
            int sz;
            sz = (si == 0) ? 0 : (si == 1) ? 1 : (si == 2) ? 5 : 15;
            for (int ws = 0; ws < 4; ws++) begin
                set_cfg(0, ws, 0, sz);
                for (int b = 0; b < 4; b++) begin
                    logic [31:0] a;
                    a = 32'h4000_0000 + 32'(b) * (32'h2000 << sz) + 32'h30;
                    xact(1'b0, a, 4'h0, 32'h0, 0);
                    chk("R3", "RAM read data", got_rd[0], init_word(a[31:2]));
                    chk("R3", "RAM bank select", 32'(last_cs), 32'(1 << b));
                    chk("R5", "RAM select cycles", 32'(d_cs), 32'(ws + 1));
                end
            end
        end

        // R9: unmapped and out-of-bank addresses
        set_cfg(0, 0, 0, 0);
        xact(1'b0, 32'h4000_8000, 4'h0, 32'h0, 0);
        chk("R9", "past last bank err", 32'(got_err), 32'd1);
        chk("R9", "past last bank no select", 32'(d_cs), 32'd0);
        set_cfg(0, 0, 0, 2);
        xact(1'b0, 32'h4002_0000, 4'h0, 32'h0, 0);
        chk("R9", "past 128K err", 32'(got_err), 32'd1);
        xact(1'b0, 32'h4001_FFFC, 4'h0, 32'h0, 0);
        chk("R3", "last word of bank 3 ok", 32'(got_err), 32'd0);
        chk("R3", "last word of bank 3 select", 32'(last_cs), 32'h08);
        xact(1'b0, 32'h2000_0000, 4'h0, 32'h0, 0);
        chk("R9", "gap region err", 32'(got_err), 32'd1);
        xact(1'b1, 32'h8000_0000, 4'hF, 32'h1, 0);
        chk("R9", "high region write err", 32'(got_err), 32'd1);
        chk("R9", "high region no strobe", 32'(d_we), 32'd0);
        xact(1'b0, 32'hC000_0000, 4'h0, 32'h0, 0);
        chk("R9", "top region err", 32'(got_err), 32'd1);

        // R6: read-modify-write for every byte-enable pattern
        for (int wi = 0; wi < 2; wi++) begin
            int ws;
            ws = (wi == 0) ? 1 : 3;
            set_cfg(0, ws, 0, 0);
            for (int be = 0; be < 16; be++) begin
                logic [31:0] a, wd, old, expv;
                a = 32'h4000_2000 + 32'(be * 4) + 32'(wi * 64);
                wd = 32'hF00D_0000 ^ (32'(be) * 32'h0101_0101);
                old = rd_model(a[31:2]);
                for (int k = 0; k < 4; k++) expv[k*8 +: 8] = be[k] ? wd[k*8 +: 8] : old[k*8 +: 8];
                xact(1'b1, a, 4'(be), wd, 0);
                chk("R6", "merged word stored", rd_model(a[31:2]), expv);
                chk("R6", "write phase cycles", 32'(d_we), 32'(ws + 1));
                chk("R6", "read phase cycles", 32'(d_oe), be == 15 ? 32'd0 : 32'(ws + 1));
                chk("R6", "select cycles", 32'(d_cs), be == 15 ? 32'(ws + 1) : 32'(2 * (ws + 1)));
                chk("R6", "full word strobes", 32'(last_wbe), 32'hF);
                xact(1'b0, a, 4'h0, 32'h0, 0);
                chk("R6", "read back merged", got_rd[0], expv);
            end
        end

        // R7: PROM sub-word writes
        set_cfg(2, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            logic [3:0]  be;
            logic [31:0] a, wd, old, expv;
            be = (i == 0) ? 4'h1 : (i == 1) ? 4'h2 : (i == 2) ? 4'h4 : (i == 3) ? 4'h8 : (i == 4) ? 4'h3 : 4'hC;
            a = 32'h0000_0400 + 32'(i * 4);
            wd = 32'h89AB_CDEF;
            old = rd_model(a[31:2]);
            for (int k = 0; k < 4; k++) expv[k*8 +: 8] = be[k] ? wd[k*8 +: 8] : old[k*8 +: 8];
            xact(1'b1, a, be, wd, 0);
            chk("R7", "PROM strobes", 32'(last_wbe), 32'(be));
            chk("R7", "PROM no read phase", 32'(d_oe), 32'd0);
            chk("R7", "PROM write cycles", 32'(d_we), 32'd3);
            chk("R7", "PROM stored", rd_model(a[31:2]), expv);
        end

        // R8: write protection
        set_cfg(1, 0, 1, 0);
        begin
            logic [31:0] old;
            old = rd_model(30'h1000_0010);
            xact(1'b1, 32'h4000_0040, 4'hF, 32'h1234_5678, 0);
            chk("R8", "protected full write err", 32'(got_err), 32'd1);
            chk("R8", "protected full write no strobe", 32'(d_we), 32'd0);
            chk("R8", "protected full write no select", 32'(d_cs), 32'd0);
            xact(1'b1, 32'h4000_0040, 4'h3, 32'h1234_5678, 0);
            chk("R8", "protected partial write err", 32'(got_err), 32'd1);
            chk("R8", "protected partial no read", 32'(d_oe), 32'd0);
            chk("R8", "memory unchanged", rd_model(30'h1000_0010), old);
            xact(1'b0, 32'h4000_0040, 4'h0, 32'h0, 0);
            chk("R8", "read allowed while protected", 32'(got_err), 32'd0);
            chk("R8", "read data while protected", got_rd[0], old);
            xact(1'b1, 32'h0000_0800, 4'hF, 32'hCAFE_F00D, 0);
            chk("R8", "PROM write unaffected", 32'(got_err), 32'd0);
            chk("R8", "PROM write strobe cycles", 32'(d_we), 32'd2);
            set_cfg(1, 0, 0, 0);
            xact(1'b1, 32'h4000_0040, 4'hF, 32'h1234_5678, 0);
            chk("R8", "unprotected write ok", 32'(got_err), 32'd0);
            chk("R8", "unprotected write stored", rd_model(30'h1000_0010), 32'h1234_5678);
        end

        // R10: bursts
        set_cfg(3, 1, 0, 0);
        xact(1'b0, 32'h4000_0100, 4'h0, 32'h0, 3);
        chk("R10", "RAM burst beats", 32'(n_got), 32'd4);
        for (int k = 0; k < 4; k++) chk("R10", "RAM burst data", got_rd[k], init_word(30'(32'h1000_0040 + 32'(k))));
        chk("R10", "RAM burst select cycles", 32'(d_cs), 32'd8);
        chk("R10", "RAM burst select held", 32'(d_fall), 32'd1);
        xact(1'b0, 32'h0000_1000, 4'h0, 32'h0, 7);
        chk("R10", "PROM burst beats", 32'(n_got), 32'd8);
        for (int k = 0; k < 8; k++) chk("R10", "PROM burst data", got_rd[k], init_word(30'(32'h400 + 32'(k))));
        chk("R10", "PROM burst select cycles", 32'(d_cs), 32'd32);
        chk("R10", "PROM burst select held", 32'(d_fall), 32'd1);
        xact(1'b1, 32'h4000_0200, 4'hF, 32'h0BAD_BEEF, 5);
        chk("R10", "write ignores length", 32'(n_got), 32'd1);
        chk("R10", "write single phase", 32'(d_we), 32'd2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule